// File: doc/BRIEF.md
# Entropy Request Command Sequencer

This block drives the command port of a downstream random number generator so that entropy keeps flowing without software involvement. It owns the request/acknowledge handshake toward the generator: one command word is presented at a time, held with the request until the generator acknowledges it, and only then is the next command picked. A status word reports which phase is active, the type of the command last issued, whether that command has been acknowledged and the status code the generator returned.

Two hardware-driven flows exist. The boot flow sends two stored words one after the other: an instantiate word, then a generate word. Both sit in loadable registers with fixed reset values. The continuous flow waits until an instantiate issued by software elsewhere has been acknowledged. After that it sends generate words taken from a replay store, and after a programmable number of generates it slips in one reseed word taken from a second replay store. Each replay store plays its entries back in the order they were pushed and wraps around to the first entry.

The generator itself, the software command path and the entropy data return are outside this block. Dropping the enable returns the sequencer to idle at any point.

Top module: `ent_cmd_seq`

## Requirements
- R1: After reset `cmdReq` is 0, `hwSts` is 0 and `recovErr` is 0. The boot instantiate register holds 0x901 and the boot generate register holds 0xFFF003.
- R2: With `enable` and `bootMode` high, the block first requests the boot instantiate word and then, once that is acknowledged, the boot generate word. After the second acknowledge it issues nothing more. `hwSts[0]` is 1 and `hwSts[1]` is 0 for the whole boot flow.
- R3: Only one command is outstanding at a time. `cmdReq` stays high with `cmdWord` stable until the cycle in which `cmdAck` is seen, and it is low in the following cycle.
- R4: With `enable` and `autoMode` high and `bootMode` low, no command is issued and `hwSts[1]` stays 0 until `swInstAck` pulses. After the pulse `hwSts[1]` is 1.
- R5: In the continuous flow, generate words come from the generate store in push order and wrap back to the first entry after the last one.
- R6: When `maxReqs` is N (N nonzero), a reseed word from the reseed store is issued after every N generate words. When `maxReqs` is 0, no reseed is ever issued.
- R7: Status layout: `hwSts[5:2]` holds bits 3:0 of the last issued command word. `hwSts[6]` is 0 while that command is outstanding and 1 once it is acknowledged. `hwSts[9:7]` holds the `cmdAckSts` value of the most recent acknowledge.
- R8: An accepted acknowledge with nonzero `cmdAckSts` sets `recovErr`. The flag stays set until a `recovErrClr` pulse clears it, and an acknowledge with zero status leaves it unchanged.
- R9: When `enable` is low at a clock edge, `cmdReq` and `hwSts[1:0]` are 0 from the next cycle on.
- R10: A `cmdAck` that arrives while no request is outstanding is ignored: `hwSts` and `recovErr` do not change.
- R11: A `bootInstLoad` or `bootGenLoad` pulse stores `cfgData` in that boot register, and the next boot flow sends the stored value.
- R12: Each replay store holds DEPTH words. A push into a full store is dropped.
- R13: When the next command is due but its store is empty, no request is raised and `hwSts[1]` stays 1. The command is issued once a word is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Sequencer enable; low forces idle |
| bootMode | input | 1 | Selects the boot flow when leaving idle (has priority) |
| autoMode | input | 1 | Selects the continuous flow when leaving idle |
| swInstAck | input | 1 | Pulse: the software-issued instantiate was acknowledged |
| cfgData | input | CMD_W | Data for the boot register loads |
| bootInstLoad | input | 1 | Load `cfgData` into the boot instantiate register |
| bootGenLoad | input | 1 | Load `cfgData` into the boot generate register |
| pushData | input | CMD_W | Word pushed into a replay store |
| genPush | input | 1 | Push `pushData` into the generate store |
| rsdPush | input | 1 | Push `pushData` into the reseed store |
| maxReqs | input | CNT_W | Generates between reseeds; 0 disables reseeds |
| cmdAck | input | 1 | Acknowledge from the generator |
| cmdAckSts | input | STS_W | Status code returned with the acknowledge |
| recovErrClr | input | 1 | Clears `recovErr` |
| cmdReq | output | 1 | Command request toward the generator |
| cmdWord | output | CMD_W | Command word presented with the request |
| hwSts | output | 10 | Status word (R7 layout; bit 0 boot active, bit 1 continuous active) |
| recovErr | output | 1 | Sticky flag: an acknowledge carried a nonzero status |

## Verification
The bench builds the block with its defaults: 32-bit words, replay stores four deep and a 16-bit request counter. The small depth lets a fifth push reach the full-store case, and four stored generates against a reseed interval of three make the generate and reseed wrap points fall on different commands within a few dozen acknowledges. Changing `maxReqs` to 0 at run time brings the reseed-free case within reach. Random acknowledge delays, random status codes and random command words exercise the hold-until-acknowledge rule and the status fields.

// File: rtl/ent_seq_pkg.sv
package ent_seq_pkg;

  localparam int TYPE_W = 4;
  localparam logic [31:0] BOOT_INS_RST = 32'h0000_0901;
  localparam logic [31:0] BOOT_GEN_RST = 32'h00FF_F003;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_BOOT_INS_LD,
    ST_BOOT_INS_REQ,
    ST_BOOT_GEN_LD,
    ST_BOOT_GEN_REQ,
    ST_BOOT_DONE,
    ST_AUTO_WAIT_SW,
    ST_AUTO_LD,
    ST_AUTO_REQ
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic ldBootIns;
    logic ldBootGen;
    logic ldGen;
    logic ldRsd;
    logic ackTake;
  } seqStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic genAvail;
    logic rsdAvail;
    logic reseedDue;
  } dpStat_t;

endpackage

// File: rtl/ent_seq_store.sv
// Replay store: words are kept in push order and read back cyclically.
module ent_seq_store #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         avail
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [PTR_W-1:0] rdPtr;
  logic             full;
  logic [CNT_W-1:0] lastCnt;

  assign full    = (cnt == CNT_W'(DEPTH));
  assign avail   = (cnt != '0);
  assign lastCnt = cnt - CNT_W'(1);
  assign head    = mem[rdPtr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      rdPtr <= '0;
    end else begin
      if (push && !full) cnt <= cnt + CNT_W'(1);
      if (pop && avail) begin
        if (CNT_W'(rdPtr) == lastCnt) rdPtr <= '0;
        else                          rdPtr <= rdPtr + PTR_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[cnt[PTR_W-1:0]] <= pushData;
  end

endmodule

// File: rtl/ent_seq_dpath.sv
module ent_seq_dpath
  import ent_seq_pkg::*;
#(
  parameter int CMD_W = 32,
  parameter int DEPTH = 4,
  parameter int CNT_W = 16,
  parameter int STS_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        stb,
  input  logic [CMD_W-1:0]  cfgData,
  input  logic              bootInstLoad,
  input  logic              bootGenLoad,
  input  logic [CMD_W-1:0]  pushData,
  input  logic              genPush,
  input  logic              rsdPush,
  input  logic [CNT_W-1:0]  maxReqs,
  input  logic [STS_W-1:0]  cmdAckSts,
  input  logic              recovErrClr,
  output dpStat_t           dpStat,
  output logic [CMD_W-1:0]  cmdWord,
  output logic [TYPE_W-1:0] cmdType,
  output logic              ackSeen,
  output logic [STS_W-1:0]  ackCode,
  output logic              recovErr
);

  localparam int N_STORE = 2;
  localparam int IDX_GEN = 0;
  localparam int IDX_RSD = 1;

  logic [N_STORE-1:0] pushV, popV, availV;
  logic [CMD_W-1:0]   headV [N_STORE];

  assign pushV[IDX_GEN] = genPush;
  assign pushV[IDX_RSD] = rsdPush;
  assign popV[IDX_GEN]  = stb.ldGen;
  assign popV[IDX_RSD]  = stb.ldRsd;

  for (genvar s = 0; s < N_STORE; s++) begin : g_store
    ent_seq_store #(.W(CMD_W), .DEPTH(DEPTH)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (pushV[s]),
      .pushData (pushData),
      .pop      (popV[s]),
      .head     (headV[s]),
      .avail    (availV[s])
    );
  end

  // boot command registers
  logic [CMD_W-1:0] bootInstQ, bootGenQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bootInstQ <= CMD_W'(BOOT_INS_RST);
      bootGenQ  <= CMD_W'(BOOT_GEN_RST);
    end else begin
      if (bootInstLoad) bootInstQ <= cfgData;
      if (bootGenLoad)  bootGenQ  <= cfgData;
    end
  end

  // generate counter between reseeds
  logic [CNT_W-1:0] genCount;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         genCount <= '0;
    else if (stb.cntClr || stb.ldRsd)   genCount <= '0;
    else if (stb.ldGen && (genCount != '1)) genCount <= genCount + CNT_W'(1);
  end

  assign dpStat.genAvail  = availV[IDX_GEN];
  assign dpStat.rsdAvail  = availV[IDX_RSD];
  assign dpStat.reseedDue = (maxReqs != '0) && (genCount >= maxReqs);

  // command word selection and status
  logic             anyLoad;
  logic [CMD_W-1:0] selWord;

  assign anyLoad = stb.ldBootIns | stb.ldBootGen | stb.ldGen | stb.ldRsd;

  always_comb begin
    if (stb.ldBootIns)      selWord = bootInstQ;
    else if (stb.ldBootGen) selWord = bootGenQ;
    else if (stb.ldGen)     selWord = headV[IDX_GEN];
    else                    selWord = headV[IDX_RSD];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdWord <= '0;
      cmdType <= '0;
      ackSeen <= 1'b0;
      ackCode <= '0;
    end else if (anyLoad) begin
      cmdWord <= selWord;
      cmdType <= selWord[TYPE_W-1:0];
      ackSeen <= 1'b0;
    end else if (stb.ackTake) begin
      ackSeen <= 1'b1;
      ackCode <= cmdAckSts;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  recovErr <= 1'b0;
    else if (stb.ackTake && (cmdAckSts != '0))   recovErr <= 1'b1;
    else if (recovErrClr)                        recovErr <= 1'b0;
  end

endmodule

// File: rtl/ent_seq_ctrl.sv
module ent_seq_ctrl
  import ent_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       bootMode,
  input  logic       autoMode,
  input  logic       swInstAck,
  input  logic       cmdAck,
  input  dpStat_t    dpStat,
  output seqStrobe_t stb,
  output logic       cmdReq,
  output logic       bootActive,
  output logic       autoActive
);

  seqState_e state, stateNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  // request and activity flags follow the registered state only
  assign cmdReq = (state == ST_BOOT_INS_REQ) || (state == ST_BOOT_GEN_REQ) ||
                  (state == ST_AUTO_REQ);
  assign bootActive = (state == ST_BOOT_INS_LD) || (state == ST_BOOT_INS_REQ) ||
                      (state == ST_BOOT_GEN_LD) || (state == ST_BOOT_GEN_REQ) ||
                      (state == ST_BOOT_DONE);
  assign autoActive = (state == ST_AUTO_LD) || (state == ST_AUTO_REQ);

  always_comb begin
    stateNext   = state;
    stb         = '0;
    stb.ackTake = cmdReq && cmdAck;
    if (!enable) begin
      stateNext  = ST_IDLE;
      stb.cntClr = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          stb.cntClr = 1'b1;
          if (bootMode)      stateNext = ST_BOOT_INS_LD;
          else if (autoMode) stateNext = ST_AUTO_WAIT_SW;
        end
        ST_BOOT_INS_LD: begin
          stb.ldBootIns = 1'b1;
          stateNext     = ST_BOOT_INS_REQ;
        end
        ST_BOOT_INS_REQ: if (cmdAck) stateNext = ST_BOOT_GEN_LD;
        ST_BOOT_GEN_LD: begin
          stb.ldBootGen = 1'b1;
          stateNext     = ST_BOOT_GEN_REQ;
        end
        ST_BOOT_GEN_REQ: if (cmdAck) stateNext = ST_BOOT_DONE;
        ST_BOOT_DONE:    stateNext = ST_BOOT_DONE;
        ST_AUTO_WAIT_SW: if (swInstAck) stateNext = ST_AUTO_LD;
        ST_AUTO_LD: begin
          if (dpStat.reseedDue) begin
            if (dpStat.rsdAvail) begin
              stb.ldRsd = 1'b1;
              stateNext = ST_AUTO_REQ;
            end
          end else if (dpStat.genAvail) begin
            stb.ldGen = 1'b1;
            stateNext = ST_AUTO_REQ;
          end
        end
        ST_AUTO_REQ: if (cmdAck) stateNext = ST_AUTO_LD;
        default: stateNext = ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ent_cmd_seq.sv
module ent_cmd_seq
  import ent_seq_pkg::*;
#(
  parameter int CMD_W = 32,
  parameter int DEPTH = 4,
  parameter int CNT_W = 16,
  parameter int STS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             bootMode,
  input  logic             autoMode,
  input  logic             swInstAck,
  input  logic [CMD_W-1:0] cfgData,
  input  logic             bootInstLoad,
  input  logic             bootGenLoad,
  input  logic [CMD_W-1:0] pushData,
  input  logic             genPush,
  input  logic             rsdPush,
  input  logic [CNT_W-1:0] maxReqs,
  input  logic             cmdAck,
  input  logic [STS_W-1:0] cmdAckSts,
  input  logic             recovErrClr,
  output logic             cmdReq,
  output logic [CMD_W-1:0] cmdWord,
  output logic [2+TYPE_W+1+STS_W-1:0] hwSts,
  output logic             recovErr
);

  seqStrobe_t        stb;
  dpStat_t           dpStat;
  logic              bootActive, autoActive, ackSeen;
  logic [TYPE_W-1:0] cmdType;
  logic [STS_W-1:0]  ackCode;

  ent_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .bootMode   (bootMode),
    .autoMode   (autoMode),
    .swInstAck  (swInstAck),
    .cmdAck     (cmdAck),
    .dpStat     (dpStat),
    .stb        (stb),
    .cmdReq     (cmdReq),
    .bootActive (bootActive),
    .autoActive (autoActive)
  );

  ent_seq_dpath #(
    .CMD_W (CMD_W),
    .DEPTH (DEPTH),
    .CNT_W (CNT_W),
    .STS_W (STS_W)
  ) u_dpath (
    .clk          (clk),
    .rst_n        (rst_n),
    .stb          (stb),
    .cfgData      (cfgData),
    .bootInstLoad (bootInstLoad),
    .bootGenLoad  (bootGenLoad),
    .pushData     (pushData),
    .genPush      (genPush),
    .rsdPush      (rsdPush),
    .maxReqs      (maxReqs),
    .cmdAckSts    (cmdAckSts),
    .recovErrClr  (recovErrClr),
    .dpStat       (dpStat),
    .cmdWord      (cmdWord),
    .cmdType      (cmdType),
    .ackSeen      (ackSeen),
    .ackCode      (ackCode),
    .recovErr     (recovErr)
  );

  assign hwSts = {ackCode, ackSeen, cmdType, autoActive, bootActive};

endmodule

// File: rtl/ent_cmd_seq_chk.sv
module ent_cmd_seq_chk #(
  parameter int CMD_W = 32,
  parameter int STS_W = 3,
  parameter int HS_W  = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             cmdReq,
  input logic             cmdAck,
  input logic [STS_W-1:0] cmdAckSts,
  input logic [CMD_W-1:0] cmdWord,
  input logic [HS_W-1:0]  hwSts,
  input logic             recovErr
);

  AST_BOOT_AUTO_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(hwSts[0] && hwSts[1])); // R2

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdReq && !cmdAck && enable) |=> (cmdReq && $stable(cmdWord))); // R3

  AST_REQ_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdReq && cmdAck) |=> !cmdReq); // R3

  AST_TYPE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cmdReq |-> (hwSts[5:2] == cmdWord[3:0])); // R7

  AST_ACK_CLEAR_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmdReq) |-> !hwSts[6]); // R7

  AST_ACK_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdReq && cmdAck) |=> (hwSts[6] && (hwSts[9:7] == $past(cmdAckSts)))); // R7

  AST_RECOV_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdReq && cmdAck && (cmdAckSts != '0)) |=> recovErr); // R8

  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!cmdReq && (hwSts[1:0] == 2'b00))); // R9

  AST_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmdReq && cmdAck) |=> $stable(hwSts[9:2])); // R10

endmodule

bind ent_cmd_seq ent_cmd_seq_chk #(
  .CMD_W (CMD_W),
  .STS_W (STS_W),
  .HS_W  (2 + ent_seq_pkg::TYPE_W + 1 + STS_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .cmdReq    (cmdReq),
  .cmdAck    (cmdAck),
  .cmdAckSts (cmdAckSts),
  .cmdWord   (cmdWord),
  .hwSts     (hwSts),
  .recovErr  (recovErr)
);

// File: tb/ent_cmd_seq_tb.sv
`timescale 1ns/1ps
module ent_cmd_seq_tb;

  localparam int CMD_W = 32;
  localparam int DEPTH = 4;
  localparam int CNT_W = 16;
  localparam int STS_W = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic enable, bootMode, autoMode, swInstAck;
  logic [CMD_W-1:0] cfgData, pushData;
  logic bootInstLoad, bootGenLoad, genPush, rsdPush;
  logic [CNT_W-1:0] maxReqs;
  logic cmdAck;
  logic [STS_W-1:0] cmdAckSts;
  logic recovErrClr;
  logic cmdReq;
  logic [CMD_W-1:0] cmdWord;
  logic [9:0] hwSts;
  logic recovErr;

  always #5 clk = ~clk;

  ent_cmd_seq #(.CMD_W(CMD_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .STS_W(STS_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .bootMode(bootMode),
    .autoMode(autoMode), .swInstAck(swInstAck), .cfgData(cfgData),
    .bootInstLoad(bootInstLoad), .bootGenLoad(bootGenLoad), .pushData(pushData),
    .genPush(genPush), .rsdPush(rsdPush), .maxReqs(maxReqs), .cmdAck(cmdAck),
    .cmdAckSts(cmdAckSts), .recovErrClr(recovErrClr), .cmdReq(cmdReq),
    .cmdWord(cmdWord), .hwSts(hwSts), .recovErr(recovErr)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench model of the replay stores and reseed interval
  logic [CMD_W-1:0] mGen [DEPTH];
  logic [CMD_W-1:0] mRsd [DEPTH];
  int mGenN, mRsdN, mGi, mRi, mCnt, mMax;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [CMD_W-1:0] expNext();
    logic [CMD_W-1:0] w;
    if (mMax != 0 && mCnt >= mMax) begin
      w = mRsd[mRi];
      mRi = (mRi + 1) % mRsdN;
      mCnt = 0;
    end else begin
      w = mGen[mGi];
      mGi = (mGi + 1) % mGenN;
      mCnt++;
    end
    return w;
  endfunction

  task automatic doReset();
    rst_n = 1'b0; enable = 0; bootMode = 0; autoMode = 0; swInstAck = 0;
    cfgData = '0; pushData = '0; bootInstLoad = 0; bootGenLoad = 0;
    genPush = 0; rsdPush = 0; maxReqs = '0; cmdAck = 0; cmdAckSts = '0;
    recovErrClr = 0;
    mGenN = 0; mRsdN = 0; mGi = 0; mRi = 0; mCnt = 0; mMax = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pushCmd(input bit toGen, input logic [CMD_W-1:0] w);
    pushData = w;
    if (toGen) begin
      genPush = 1;
      if (mGenN < DEPTH) begin mGen[mGenN] = w; mGenN++; end
    end else begin
      rsdPush = 1;
      if (mRsdN < DEPTH) begin mRsd[mRsdN] = w; mRsdN++; end
    end
    @(negedge clk);
    genPush = 0; rsdPush = 0;
  endtask

  // wait for a request, check it, hold for dly cycles, acknowledge with sts
  task automatic serve(input logic [CMD_W-1:0] expW, input logic [2:0] sts,
                       input int dly, input string tag);
    int w = 0;
    while (!cmdReq && w < 60) begin @(negedge clk); w++; end
    chk(cmdReq, {tag, " request raised"}, 32'(cmdReq), 1);
    if (!cmdReq) return;
    chk(cmdWord == expW, {tag, " command word"}, cmdWord, expW);
    chk(hwSts[5:2] == expW[3:0] && !hwSts[6], "R7 type/ack while outstanding",
        32'(hwSts), {22'd0, 3'd0, 1'b0, expW[3:0], 2'b00} | 32'(hwSts[1:0]));
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk(cmdReq && cmdWord == expW, "R3 request held until ack", cmdWord, expW);
    end
    cmdAck = 1; cmdAckSts = sts;
    @(negedge clk);
    cmdAck = 0; cmdAckSts = '0;
    chk(!cmdReq, "R3 request drops after ack", 32'(cmdReq), 0);
    chk(hwSts[6] && hwSts[9:7] == sts, "R7 ack bit and status code",
        {29'd0, hwSts[9:7]} | (32'(hwSts[6]) << 8), {29'd0, sts} | 32'h100);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [CMD_W-1:0] bi, bg, w;
    logic [9:0] snap;
    logic [2:0] s;
    void'($urandom(32'h5EED_0042));

    // ---------- R1 reset state ----------
    doReset();
    chk(!cmdReq, "R1 reset cmdReq", 32'(cmdReq), 0);
    chk(hwSts == '0, "R1 reset hwSts", 32'(hwSts), 0);
    chk(!recovErr, "R1 reset recovErr", 32'(recovErr), 0);

    // ---------- R2 boot flow with reset-value registers ----------
    enable = 1; bootMode = 1;
    @(negedge clk);
    chk(hwSts[1:0] == 2'b01, "R2 boot status bits", 32'(hwSts[1:0]), 1);
    serve(32'h0000_0901, 3'd0, 1, "R1 R2 boot instantiate reset value");
    chk(hwSts[1:0] == 2'b01, "R2 boot status between commands", 32'(hwSts[1:0]), 1);
    serve(32'h00FF_F003, 3'd0, 2, "R1 R2 boot generate reset value");
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(!cmdReq && hwSts[1:0] == 2'b01, "R2 no request after boot flow",
          32'(cmdReq), 0);
    end

    // ---------- R9 disable returns to idle ----------
    enable = 0;
    @(negedge clk);
    chk(hwSts[1:0] == 2'b00 && !cmdReq, "R9 idle after disable", 32'(hwSts[1:0]), 0);

    // ---------- R10 stray acknowledge ignored ----------
    snap = hwSts;
    cmdAck = 1; cmdAckSts = 3'd5;
    @(negedge clk);
    cmdAck = 0; cmdAckSts = '0;
    @(negedge clk);
    chk(hwSts == snap, "R10 stray ack leaves hwSts", 32'(hwSts), 32'(snap));
    chk(!recovErr, "R10 stray ack leaves recovErr", 32'(recovErr), 0);

    // ---------- R11 loaded boot words, R8 error flag ----------
    bi = {$urandom() >> 4, 4'h1};
    bg = {$urandom() >> 4, 4'h3};
    cfgData = bi; bootInstLoad = 1; @(negedge clk); bootInstLoad = 0;
    cfgData = bg; bootGenLoad = 1;  @(negedge clk); bootGenLoad = 0;
    enable = 1; bootMode = 1;
    serve(bi, 3'd0, int'($urandom() % 4), "R11 loaded instantiate word");
    chk(!recovErr, "R8 zero status keeps flag clear", 32'(recovErr), 0);
    serve(bg, 3'd3, int'($urandom() % 4), "R11 loaded generate word");
    chk(recovErr, "R8 nonzero status sets flag", 32'(recovErr), 1);
    repeat (3) @(negedge clk);
    chk(recovErr, "R8 flag is sticky", 32'(recovErr), 1);
    recovErrClr = 1; @(negedge clk); recovErrClr = 0;
    chk(!recovErr, "R8 flag cleared", 32'(recovErr), 0);

    // ---------- R4 R5 R6 R12 continuous flow, reseed every 3 ----------
    doReset();
    for (int i = 0; i < 5; i++) pushCmd(1'b1, {$urandom() >> 4, 4'h3});
    for (int i = 0; i < 2; i++) pushCmd(1'b0, {$urandom() >> 4, 4'h2});
    chk(mGenN == DEPTH, "R12 bench model depth", mGenN, DEPTH);
    maxReqs = 16'd3; mMax = 3;
    enable = 1; autoMode = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(!cmdReq && !hwSts[1], "R4 nothing before software instantiate ack",
          32'(hwSts[1:0]) | (32'(cmdReq) << 4), 0);
    end
    swInstAck = 1; @(negedge clk); swInstAck = 0;
    chk(hwSts[1:0] == 2'b10, "R4 auto status after instantiate ack", 32'(hwSts[1:0]), 2);
    for (int k = 0; k < 18; k++) begin
      w = expNext();
      s = ($urandom() % 4 == 0) ? 3'(($urandom() % 7) + 1) : 3'd0;
      serve(w, s, int'($urandom() % 4), (w[3:0] == 4'h2) ? "R6 reseed order" :
            "R5 R12 generate replay order");
      chk(hwSts[1:0] == 2'b10, "R4 auto status held", 32'(hwSts[1:0]), 2);
    end

    // ---------- R9 disable while a request is outstanding ----------
    begin
      int t = 0;
      while (!cmdReq && t < 20) begin @(negedge clk); t++; end
    end
    enable = 0;
    @(negedge clk);
    chk(!cmdReq && hwSts[1:0] == 2'b00, "R9 disable drops outstanding request",
        32'(cmdReq) | (32'(hwSts[1:0]) << 4), 0);

    // ---------- R6 no reseeds when limit is zero ----------
    doReset();
    for (int i = 0; i < 3; i++) pushCmd(1'b1, {$urandom() >> 4, 4'h3});
    pushCmd(1'b0, {$urandom() >> 4, 4'h2});
    maxReqs = '0; mMax = 0;
    enable = 1; autoMode = 1;
    @(negedge clk);
    swInstAck = 1; @(negedge clk); swInstAck = 0;
    for (int k = 0; k < 10; k++) begin
      w = expNext();
      serve(w, 3'd0, int'($urandom() % 3), "R6 zero limit gives only generates");
    end

    // ---------- R13 empty generate store stalls ----------
    doReset();
    maxReqs = 16'd2; mMax = 2;
    enable = 1; autoMode = 1;
    @(negedge clk);
    swInstAck = 1; @(negedge clk); swInstAck = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(!cmdReq && hwSts[1], "R13 stall while store empty",
          32'(cmdReq) | (32'(hwSts[1]) << 4), 32'h10);
    end
    pushCmd(1'b1, {$urandom() >> 4, 4'h3});
    w = expNext();
    serve(w, 3'd0, 0, "R13 issue after push");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule